// File: doc/BRIEF.md
# I2C Target Engine with Host-Serviced Status Flags

This block answers on an I2C bus as a target with a single 7-bit address. It filters SCL and SDA through short synchronizers, finds START and STOP conditions, and shifts in the address byte. When the address matches, it acknowledges and records the transfer direction. For a write it receives bytes and acknowledges each one, or refuses them while a control bit asks it to. For a read it shifts out, MSB first, the byte the host placed in its data register. Both bus lines are open-drain: the block only pulls them low, through two output-enable pins.

The host moves the transfer forward one step at a time. After an address match, and after every byte, the engine holds SCL low until the host clears the flag that is pending: address matched, data received, or data empty. A small register port gives access to control, status, interrupt enable, own address and data. Status bits are cleared by writing 0 and left alone by writing 1. One interrupt line combines all enabled status bits.

Top module: `i2c_tgt`

## Requirements
- R1: After reset every register reads 0, irq is low and neither scl_oe nor sda_oe is asserted.
- R2: The register map, selected by reg_addr, is: 0 control (bits 3:0 kept, upper bits read 0), 1 status (bits 6:0), 2 interrupt enable (bits 6:0), 3 own address (7 bits, right-aligned), 4 data (a write loads the transmit byte, a read returns the last received byte). Writing status clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R3: When an address byte whose upper seven bits equal the own address is received, the engine drives ACK (SDA low) on the ninth clock and sets status bit 0. Any other address gets no ACK and sets no flag.
- R4: On an address match, status bit 5 takes the value of the R/W bit: 1 for a read request, 0 for a write request.
- R5: In a write transfer each received byte is acknowledged, status bit 1 is set, and the byte can be read at offset 4.
- R6: When control bit 0 is 1 at the moment a byte has been received, that byte is answered with NACK (SDA left high). The byte is still stored and status bit 1 is still set.
- R7: After the address ACK and after each data byte, the engine drives scl_oe until the pending flag is cleared: status bit 0 after the address, bit 1 after a received byte, bit 3 in read mode. It releases SCL within two clocks of the clearing write.
- R8: In a read transfer the data register is copied into the shift register at the start of each byte and status bit 3 is set. Bits go out MSB first. Status bit 2 is set when the master acknowledges a byte. A master NACK ends the transfer.
- R9: A STOP condition after the engine was addressed sets status bit 4 and returns the engine to idle. A STOP without a preceding match sets nothing.
- R10: With control bit 1 set, a general-call address (byte 0x00) is acknowledged and sets status bits 6 and 0. With control bit 1 clear it is not acknowledged.
- R11: irq is high exactly when some status bit is set together with the same bit of the interrupt enable register.
- R12: While control bit 2 (enable) is 0, the engine ignores the bus: no ACK, no stretching, no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench acts as the bus master and also plays the host. A design that stopped stretching would let the master clock on past an unserviced flag, so the bench checks that scl_oe is held while a flag is pending and dropped after the flag is cleared. A write of 1 to a status bit must leave it set, so a design that cleared bits on writing 1 would lose the transmit-mode flag. Each corner case below has its own test, together with the wrong result it would give on a faulty design:
- Force-NACK is set between two bytes; a design that ignored it would acknowledge the second byte.
- The second read byte ends in a master NACK; a wrongly set data-transmitted flag would show up in the status.
- A mismatched address followed by STOP must set no stop flag; a design that flagged every STOP would report one.
- A general-call byte is sent with general call enabled and then disabled; a design that ignored the enable bit would acknowledge both.

// File: rtl/i2c_tgt.sv
module i2c_tgt #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2, A_OWN = 3'd3, A_DATA = 3'd4;
  localparam logic [3:0] BITS = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_DACK, S_TX, S_RACK, S_HOLD} st_t;

  logic [SYNC:0] scl_sh, sda_sh;
  logic [3:0] ctrl_q;
  logic [6:0] stat_q, ien_q, own_q, mask_q, mask_d, set_v, stat_d;
  logic [7:0] tx_q, rx_q, sh_q, sh_d;
  logic [3:0] cnt_q, cnt_d;
  st_t        st_q, st_d;
  logic nack_q, nack_d, adr_q, adr_d, ack_q, ack_d, txm_q, txm_d;
  logic stm_ld, rx_ld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC-1:0], scl_in};
      sda_sh <= {sda_sh[SYNC-1:0], sda_in};
    end

  wire scl_now = scl_sh[SYNC-1], scl_old = scl_sh[SYNC];
  wire sda_now = sda_sh[SYNC-1], sda_old = sda_sh[SYNC];
  wire rise    = scl_now & ~scl_old;
  wire fall    = ~scl_now & scl_old;
  wire start_c = scl_now & scl_old & sda_old & ~sda_now;
  wire stop_c  = scl_now & scl_old & ~sda_old & sda_now;
  wire en      = ctrl_q[2];
  wire own_hit = sh_q[7:1] == own_q;
  wire gc_hit  = ctrl_q[1] && sh_q == 8'h00;
  wire stat_wr = reg_we && reg_addr == A_STAT;

  always_comb begin
    st_d = st_q; sh_d = sh_q; cnt_d = cnt_q; mask_d = mask_q;
    nack_d = nack_q; adr_d = adr_q; ack_d = ack_q; txm_d = txm_q;
    set_v = '0; stm_ld = 1'b0; rx_ld = 1'b0;
    if (!en) begin
      st_d = S_IDLE;
      adr_d = 1'b0;
    end else if (stop_c) begin
      set_v[4] = adr_q;
      adr_d = 1'b0;
      st_d = S_IDLE;
    end else if (start_c) begin
      st_d = S_ADDR;
      cnt_d = '0;
    end else begin
      case (st_q)
        S_ADDR, S_RX: begin
          if (rise) begin
            sh_d = {sh_q[6:0], sda_now};
            cnt_d = cnt_q + 4'd1;
          end else if (fall && cnt_q == BITS) begin
            if (st_q == S_RX) begin
              rx_ld = 1'b1;
              set_v[1] = 1'b1;
              nack_d = ctrl_q[0];
              st_d = S_DACK;
            end else if (own_hit || gc_hit) begin
              set_v[0] = 1'b1;
              set_v[6] = gc_hit;
              stm_ld = 1'b1;
              txm_d = sh_q[0];
              adr_d = 1'b1;
              st_d = S_AACK;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        S_AACK: if (fall) begin st_d = S_HOLD; mask_d = 7'h01; end
        S_DACK: if (fall) begin st_d = S_HOLD; mask_d = 7'h02; end
        S_HOLD: if ((stat_q & mask_q) == '0) begin
          cnt_d = '0;
          if (txm_q) begin
            sh_d = tx_q;
            set_v[3] = 1'b1;
            st_d = S_TX;
          end else begin
            st_d = S_RX;
          end
        end
        S_TX: begin
          if (rise) cnt_d = cnt_q + 4'd1;
          else if (fall) begin
            if (cnt_q == BITS) st_d = S_RACK;
            else sh_d = {sh_q[6:0], 1'b0};
          end
        end
        S_RACK: begin
          if (rise) ack_d = ~sda_now;
          else if (fall) begin
            if (ack_q) begin
              set_v[2] = 1'b1;
              mask_d = 7'h08;
              st_d = S_HOLD;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_d = (stat_wr ? (stat_q & reg_wdata[6:0]) : stat_q) | set_v;
    if (stm_ld) stat_d[5] = sh_q[0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0; stat_q <= '0; ien_q <= '0; own_q <= '0;
      tx_q <= '0; rx_q <= '0; sh_q <= '0; cnt_q <= '0; mask_q <= '0;
      st_q <= S_IDLE; nack_q <= 1'b0; adr_q <= 1'b0; ack_q <= 1'b0; txm_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) ctrl_q <= reg_wdata[3:0];
      if (reg_we && reg_addr == A_IEN)  ien_q  <= reg_wdata[6:0];
      if (reg_we && reg_addr == A_OWN)  own_q  <= reg_wdata[6:0];
      if (reg_we && reg_addr == A_DATA) tx_q   <= reg_wdata;
      if (rx_ld) rx_q <= sh_q;
      stat_q <= stat_d;
      st_q <= st_d; sh_q <= sh_d; cnt_q <= cnt_d; mask_q <= mask_d;
      nack_q <= nack_d; adr_q <= adr_d; ack_q <= ack_d; txm_q <= txm_d;
    end

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0, ctrl_q};
      A_STAT:  reg_rdata = {1'b0, stat_q};
      A_IEN:   reg_rdata = {1'b0, ien_q};
      A_OWN:   reg_rdata = {1'b0, own_q};
      A_DATA:  reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase

  assign irq    = |(stat_q & ien_q);
  assign scl_oe = st_q == S_HOLD;
  assign sda_oe = (st_q == S_AACK) | (st_q == S_DACK && !nack_q) | (st_q == S_TX && !sh_q[7]);

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ctrl_q,
  input logic [6:0] stat_q,
  input logic [6:0] mask_q,
  input logic       scl_oe,
  input logic       sda_oe
);

  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] && !$past(ctrl_q[2]) |-> !sda_oe && !scl_oe);

  assert_ack_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> sda_oe);

  assert_forced_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[1]) && $past(ctrl_q[0]) |-> !sda_oe);

  assert_data_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[1]) && !$past(ctrl_q[0]) |-> sda_oe);

  assert_stretch_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe && ((stat_q & mask_q) == 7'h00) |=> !scl_oe);

endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .mask_q(mask_q), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_tgt_bench.sv
module i2c_tgt_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic scl_m = 1'b1, sda_m = 1'b1;
  wire scl_ln = scl_m & ~scl_oe;
  wire sda_ln = sda_m & ~sda_oe;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_tgt u_i2c_tgt (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_ln), .sda_in(sda_ln), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, IEN = 3'd2, OWN = 3'd3, DATA = 3'd4;
  localparam logic [6:0] ME = 7'h2A;

  // {offset, write value, expected read-back}
  localparam logic [18:0] VEC [6] = '{
    {CTRL, 8'hFF, 8'h0F}, {IEN, 8'hFF, 8'h7F}, {OWN, 8'hAB, 8'h2B},
    {STAT, 8'hFF, 8'h00}, {IEN, 8'h00, 8'h00}, {CTRL, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic m_start;
    sda_m = 1'b1; scl_m = 1'b1; wt(8);
    sda_m = 1'b0; wt(8);
    scl_m = 1'b0; wt(8);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wt(4);
    scl_m = 1'b1;
    while (scl_ln !== 1'b1) @(negedge clk);
    wt(8); r = sda_ln;
    scl_m = 1'b0; wt(8);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wt(4);
    scl_m = 1'b1;
    while (scl_ln !== 1'b1) @(negedge clk);
    wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ackbit);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ackbit);
  endtask

  task automatic m_rbyte(input logic nak, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(nak, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic a;
    wt(4); rst_n = 1'b1; wt(2);
    // R1 reset state
    for (int k = 0; k < 5; k++) begin rd(3'(k), v); chk("R1 reg", v, 0); end
    chk("R1 irq", irq, 0); chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);

    // R2 register walk from the vector table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk("R2 readback", v, VEC[i][7:0]);
    end

    wr(OWN, {1'b0, ME}); wr(CTRL, 8'h04); wr(IEN, 8'h01);

    // Write transfer: R3 R4 R5 R6 R7 R9 R11
    m_start; m_wbyte({ME, 1'b0}, a);
    chk("R3 ack own addr", a, 0);
    rd(STAT, v); chk("R4 write dir status", v, 8'h01);
    chk("R11 irq on enabled flag", irq, 1);
    wt(4); chk("R7 stretch after addr", scl_oe, 1);
    wr(STAT, 8'hFE); wt(2);
    chk("R7 release after clear", scl_oe, 0);
    chk("R11 irq after clear", irq, 0);
    m_wbyte(8'hC3, a); chk("R5 data ack", a, 0);
    rd(STAT, v); chk("R5 rx flag", v, 8'h02);
    rd(DATA, v); chk("R5 rx data", v, 8'hC3);
    chk("R7 stretch after data", scl_oe, 1);
    wr(CTRL, 8'h05); wr(STAT, 8'h00);
    m_wbyte(8'h5A, a); chk("R6 forced nack", a, 1);
    rd(DATA, v); chk("R6 byte kept", v, 8'h5A);
    rd(STAT, v); chk("R6 rx flag", v, 8'h02);
    wr(CTRL, 8'h04); wr(STAT, 8'h00);
    m_stop; rd(STAT, v); chk("R9 stop flag", v, 8'h10);
    wr(STAT, 8'h00);

    // Read transfer: R4 R8 R2 (write 1 keeps)
    m_start; m_wbyte({ME, 1'b1}, a);
    chk("R3 ack read addr", a, 0);
    rd(STAT, v); chk("R4 read dir status", v, 8'h21);
    wr(DATA, 8'hA5); wr(STAT, 8'hFE); wt(2);
    rd(STAT, v); chk("R2 write-one keeps, R8 empty set", v, 8'h28);
    m_rbyte(1'b0, v); chk("R8 first byte", v, 8'hA5);
    rd(STAT, v); chk("R8 transmitted flag", v, 8'h2C);
    chk("R7 stretch in read", scl_oe, 1);
    wr(DATA, 8'h3C); wr(STAT, 8'hF3);
    m_rbyte(1'b1, v); chk("R8 second byte", v, 8'h3C);
    m_stop; rd(STAT, v); chk("R8 nack end, R9 stop", v, 8'h38);
    wr(STAT, 8'h00);

    // Mismatch: R3 R9
    m_start; m_wbyte(8'h22, a); chk("R3 mismatch nack", a, 1);
    m_stop; rd(STAT, v); chk("R9 no stop flag unaddressed", v, 8'h00);

    // General call: R10
    wr(CTRL, 8'h06);
    m_start; m_wbyte(8'h00, a); chk("R10 gc ack", a, 0);
    rd(STAT, v); chk("R10 gc flags", v, 8'h41);
    wr(STAT, 8'h00); m_stop; wr(STAT, 8'h00);
    wr(CTRL, 8'h04);
    m_start; m_wbyte(8'h00, a); chk("R10 gc refused", a, 1);
    m_stop; rd(STAT, v); chk("R10 no flags", v, 8'h00);

    // Disabled: R12
    wr(CTRL, 8'h00);
    m_start; m_wbyte({ME, 1'b0}, a); chk("R12 no ack disabled", a, 1);
    chk("R12 no stretch", scl_oe, 0);
    m_stop; rd(STAT, v); chk("R12 no flags", v, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule